// File: doc/BRIEF.md
# Sequential-Address Bus Codec with Increment Line

This block lowers switching on a processor address bus by adding one extra wire. An encoder sits at the source of the bus and a decoder at the destination. The encoder compares each new address with the last address it sent, plus one word stride. If the new address is exactly that value, the encoder raises the increment line and leaves the address lines as they are. If it is any other value, the encoder drives the address onto the lines as it is and drops the increment line.

The decoder tracks the same reference address. When the increment line is high, it rebuilds the address by adding the stride to its reference. When the line is low, it takes the bus value directly. A run of consecutive word addresses therefore causes no toggling on any wire after the first word of the run.

The stride is the word size in bytes, which is the word width divided by eight. All address arithmetic wraps modulo two to the power of the address width. A parameter selects whether the decoded address comes straight off the bus or through a pipeline register.

Top module: `seqaddr_codec`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bus_valid`, `bus_inc` and `out_valid` are 0 and `bus_addr` is all zeros. `out_valid` follows `in_valid` with a latency of 1 cycle, or 2 cycles when `OUT_REG` is 1.
- R2: A valid address equal to the previous valid address plus the stride is a sequential address. One cycle later, `bus_inc` is 1 and `bus_addr` keeps the value it had in the cycle before.
- R3: Any other valid address, including a repeat of the previous address, is driven onto `bus_addr` one cycle later with `bus_inc` at 0.
- R4: Every valid input address appears on `out_addr` with `out_valid` high after the latency given in R1, whether it was sent sequentially or not.
- R5: The stride is `WORD_BITS/8`, which is 4 for the default 32-bit word. Stepping past the top of the address space wraps to the bottom, so 0xFC followed by 0x00 is sequential on an 8-bit address.
- R6: In a cycle with `in_valid` low, the reference address is left unchanged. One cycle later `bus_valid` is 0, and `bus_addr` and `bus_inc` hold their values. The next valid address is compared with the last valid one.
- R7: Once the increment line is high, further consecutive sequential addresses cause zero transitions on `bus_addr` and `bus_inc` together.
- R8: After reset the reference address is zero. A first address equal to one stride is encoded as sequential, and a first address of zero is sent as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source address qualifier |
| in_addr | input | ADDR_W | Binary source address |
| bus_valid | output | 1 | Bus transfer qualifier |
| bus_inc | output | 1 | Increment line: 1 means the address follows on by one stride |
| bus_addr | output | ADDR_W | Address lines of the encoded bus |
| out_valid | output | 1 | Decoded address qualifier |
| out_addr | output | ADDR_W | Decoded address at the destination |

## Verification
The assertions assume that `in_valid` is low throughout reset, so that the latency relation holds from the first cycle after reset is released. They also assume that `in_addr` is a plain binary address whose meaning does not depend on earlier cycles. The bench holds `in_valid` at 0 during every reset pulse and drives inputs only on falling edges. It uses an 8-bit address with the default stride of 4. It sweeps previous and next address pairs over the whole 8-bit range, runs long sequential streams through the wrap point, and places idle gaps between related transfers.

// File: rtl/seqaddr_pkg.sv
package seqaddr_pkg;

   localparam int unsigned BYTE_W = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/seqaddr_next.sv
// Reference-plus-stride adder shared by both ends of the link.
module seqaddr_next #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STRIDE = 4
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt
);
   import seqaddr_pkg::*;

   localparam int unsigned          LOW_W    = $clog2(STRIDE);
   localparam logic [ADDR_W-1:0]    STRIDE_V = ADDR_W'(STRIDE);

   generate
      if (is_pow2(STRIDE) && (LOW_W > 0)) begin : g_shift_inc
         localparam int unsigned     UP_W   = ADDR_W - LOW_W;
         localparam logic [UP_W-1:0] ONE_UP = UP_W'(1);
         // byte-offset field passes straight through; only word index counts
         assign nxt = {cur[ADDR_W-1:LOW_W] + ONE_UP, cur[LOW_W-1:0]};
      end else begin : g_full_add
         assign nxt = cur + STRIDE_V;
      end
   endgenerate

   // R5: whichever adder variant is built, it steps by exactly one stride, modulo 2^ADDR_W
   always_comb begin
      a_r5_stride_step : assert (ADDR_W'(nxt - cur) == STRIDE_V);
   end

endmodule

// File: rtl/seqaddr_enc.sv
module seqaddr_enc #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              bus_valid,
   output logic              bus_inc,
   output logic [ADDR_W-1:0] bus_addr
);

   logic [ADDR_W-1:0] ref_q;
   logic [ADDR_W-1:0] ref_step;
   logic              follows;

   seqaddr_next #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_step (
      .cur (ref_q),
      .nxt (ref_step)
   );

   assign follows = (in_addr == ref_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q     <= '0;
         bus_valid <= 1'b0;
         bus_inc   <= 1'b0;
         bus_addr  <= '0;
      end else begin
         bus_valid <= in_valid;
         if (in_valid) begin
            ref_q   <= in_addr;
            bus_inc <= follows;
            if (!follows) begin
               bus_addr <= in_addr;
            end
         end
      end
   end

   // R2: a sequential transfer leaves the address lines frozen
   a_r2_lines_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_inc) |-> $stable(bus_addr));

   // R3: a non-sequential transfer carries the source address verbatim
   a_r3_direct_send : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_inc) |-> (bus_addr == $past(in_addr)));

   // R6: an idle input cycle disturbs no bus wire
   a_r6_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!bus_valid && $stable(bus_addr) && $stable(bus_inc)));

endmodule

// File: rtl/seqaddr_dec.sv
module seqaddr_dec #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned STRIDE  = 4,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_inc,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr
);

   logic [ADDR_W-1:0] ref_q;
   logic [ADDR_W-1:0] ref_step;
   logic [ADDR_W-1:0] rebuilt;

   seqaddr_next #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_step (
      .cur (ref_q),
      .nxt (ref_step)
   );

   assign rebuilt = bus_inc ? ref_step : bus_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
      end else if (bus_valid) begin
         ref_q <= rebuilt;
      end
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic              v_q;
         logic [ADDR_W-1:0] a_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               a_q <= '0;
            end else begin
               v_q <= bus_valid;
               if (bus_valid) begin
                  a_q <= rebuilt;
               end
            end
         end
         assign out_valid = v_q;
         assign out_addr  = a_q;
      end else begin : g_comb_out
         assign out_valid = bus_valid;
         assign out_addr  = rebuilt;
      end
   endgenerate

   // R6: the receiver reference moves only on a valid bus transfer
   a_r6_ref_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> $stable(ref_q));

endmodule

// File: rtl/seqaddr_codec.sv
module seqaddr_codec #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WORD_BITS = 32,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              bus_valid,
   output logic              bus_inc,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr
);
   import seqaddr_pkg::*;

   localparam int unsigned STRIDE = WORD_BITS / BYTE_W;

   generate
      if ((WORD_BITS % BYTE_W) != 0 || WORD_BITS < BYTE_W) begin : g_bad_word
         $error("seqaddr_codec: WORD_BITS must be a positive multiple of 8");
      end
      if (ADDR_W <= $clog2(STRIDE) || ADDR_W < 2) begin : g_bad_addr
         $error("seqaddr_codec: ADDR_W too narrow for the word stride");
      end
   endgenerate

   seqaddr_enc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_addr   (in_addr),
      .bus_valid (bus_valid),
      .bus_inc   (bus_inc),
      .bus_addr  (bus_addr)
   );

   seqaddr_dec #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .OUT_REG(OUT_REG)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_inc   (bus_inc),
      .bus_addr  (bus_addr),
      .out_valid (out_valid),
      .out_addr  (out_addr)
   );

   generate
      if (OUT_REG) begin : g_chk_lat2
         // R1: the output qualifier trails the input qualifier by two cycles
         a_r1_valid_latency : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid, 2));
         // R4: the address is rebuilt at the destination
         a_r4_roundtrip : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_addr == $past(in_addr, 2)));
      end else begin : g_chk_lat1
         // R1: the output qualifier trails the input qualifier by one cycle
         a_r1_valid_latency : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
         // R4: the address is rebuilt at the destination
         a_r4_roundtrip : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_addr == $past(in_addr)));
      end
   endgenerate

endmodule

// File: tb/tb_seqaddr_codec.sv
`timescale 1ns/100ps
module tb_seqaddr_codec;

   localparam int unsigned AW = 8;
   localparam logic [AW-1:0] STEP = 8'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          bus_valid, bus_inc, out_valid;
   logic [AW-1:0] bus_addr, out_addr;

   int n_checks = 0;
   int n_fail   = 0;
   int trans    = 0;
   bit done     = 1'b0;
   logic [AW-1:0] ref_m = '0;

   always #2.5 clk = ~clk;

   seqaddr_codec #(.ADDR_W(AW), .WORD_BITS(32), .OUT_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .bus_valid(bus_valid), .bus_inc(bus_inc), .bus_addr(bus_addr),
      .out_valid(out_valid), .out_addr(out_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      chk(!bus_valid && !bus_inc && !out_valid, "R1 in reset", {bus_valid, bus_inc, out_valid}, 0);
      chk(bus_addr == '0, "R1 bus in reset", bus_addr, 0);
      rst_n = 1'b1;
      ref_m = '0;
      @(negedge clk);
      chk(!bus_valid && !bus_inc && !out_valid, "R1 after release", {bus_valid, bus_inc, out_valid}, 0);
   endtask

   // drive one valid address at a falling edge, check one cycle later
   task automatic xfer(input logic [AW-1:0] a);
      logic [AW-1:0] prev_bus;
      logic          prev_inc;
      bit            exp_seq;
      prev_bus = bus_addr;
      prev_inc = bus_inc;
      exp_seq  = (a == AW'(ref_m + STEP));
      in_valid = 1'b1;
      in_addr  = a;
      @(negedge clk);
      chk(bus_valid == 1'b1, "R1 bus_valid", bus_valid, 1);
      if (exp_seq) begin
         chk(bus_inc == 1'b1, "R2 inc line", bus_inc, 1);
         chk(bus_addr == prev_bus, "R2 frozen lines", bus_addr, prev_bus);
      end else begin
         chk(bus_inc == 1'b0, "R3 inc line", bus_inc, 0);
         chk(bus_addr == a, "R3 direct lines", bus_addr, a);
      end
      chk(out_valid && out_addr == a, "R4 decoded", out_addr, a);
      trans += $countones({prev_inc, prev_bus} ^ {bus_inc, bus_addr});
      ref_m = a;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         logic [AW-1:0] pb;
         logic          pi;
         pb = bus_addr;
         pi = bus_inc;
         in_valid = 1'b0;
         in_addr  = ~in_addr;
         @(negedge clk);
         chk(!bus_valid && !out_valid, "R6 idle valid", {bus_valid, out_valid}, 0);
         chk(bus_addr == pb && bus_inc == pi, "R6 idle hold", {bus_inc, bus_addr}, {pi, pb});
      end
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R8: first transfer of one stride is sequential
      xfer(8'h04);
      chk(bus_inc == 1'b1 && bus_addr == 8'h00, "R8 first stride", {bus_inc, bus_addr}, 9'h100);
      do_reset();
      // R8: first transfer of zero goes raw
      xfer(8'h00);
      chk(bus_inc == 1'b0, "R8 first zero", bus_inc, 0);

      // R5: wrap across the top of the space
      xfer(8'hFC);
      xfer(8'h00);
      chk(bus_inc == 1'b1 && out_addr == 8'h00, "R5 wrap", {bus_inc, out_addr}, 9'h100);

      // R7: long sequential run through the wrap point
      xfer(8'h40);
      xfer(8'h44);
      trans = 0;
      for (int i = 2; i < 72; i++) xfer(AW'(8'h40 + i * 4));
      chk(trans == 0, "R7 run transitions", trans, 0);

      // R6: idle gap keeps reference; next follows from last valid
      xfer(8'h90);
      idle(3);
      xfer(8'h94);
      chk(bus_inc == 1'b1, "R6 after gap", bus_inc, 1);
      xfer(8'h94);
      chk(bus_inc == 1'b0, "R3 repeat", bus_inc, 0);

      // R2 R3 R4: near-exhaustive pairs
      for (int p = 0; p < 256; p += 5) begin
         for (int q = 0; q < 256; q++) begin
            xfer(AW'(p));
            xfer(AW'(q));
         end
      end

      idle(1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R4 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule